// File: doc/BRIEF.md
# Timer-Driven Pulse-Width Modulator

This block produces a pulse-width modulated waveform from an 8-bit up-counting timer. The timer advances once every four prescaled clock steps. A 2-bit phase counter marks those four steps, and together with the timer it forms a 10-bit count. The timer restarts after it reaches the value held in the period register. A 10-bit duty value is compared against the 10-bit count, so the pulse width can be set four times more finely than the period.

Software writes the period, the upper eight duty bits, the two fractional duty bits and a control byte through a simple write port. The control byte holds the timer enable, the prescale select (divide by 1, 4 or 16) and the pin output enable. New duty values are written to a shadow copy. The shadow copy is taken into the compare register only at a period restart, so a waveform is never cut short or stretched by a write in the middle of a period. A one-clock flag marks every period restart.

Top module: `pwm_timer_gen`

## Requirements
- R1: Writes decode `wr_addr` as follows: 0 is the period byte, 1 is duty bits [9:2], 2 is duty bits [1:0] (taken from `wr_data[1:0]`), and 3 is the control byte. In the control byte, bit 0 is the timer enable, bits [2:1] are the prescale select and bit 3 is the output enable.
- R2: With the period byte P and prescale ratio N, `period_hit` pulses for exactly one clock per period, and consecutive pulses are 4·(P+1)·N clocks apart.
- R3: Prescale select 0 gives a ratio of 1, select 1 gives 4, and selects 2 and 3 both give 16.
- R4: A period whose active duty is D, with 0 < D < 4·(P+1), has `pwm_out` high for D·N clocks, starting in the clock where `period_hit` is high. The two fractional duty bits each add N clocks.
- R5: A period whose active duty is zero keeps `pwm_out` low for the whole period.
- R6: A period whose active duty is 4·(P+1) or more keeps `pwm_out` high for the whole period.
- R7: A duty written during a period does not change that period. It takes effect from the next period restart.
- R8: While the output enable is clear, `pwm_out` stays low and the timer and `period_hit` keep running.
- R9: While the timer enable is clear, the prescaler, phase and timer hold their values, `pwm_out` is low and `period_hit` does not pulse. When the timer is enabled again, the count resumes from where it stopped, so the period in progress is lengthened by the number of disabled clocks. The output stays low until the next restart.
- R10: After reset all registers are zero, `pwm_out` and `period_hit` are low, and the timer stays stopped.
- R11: After the timer is first enabled following a reset, `pwm_out` stays low until the first `period_hit`, because the active duty starts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Modulated output pin, low when released |
| period_hit | output | 1 | One-clock pulse at each period restart |

## Verification
The hardest cases to reach from the ports are the ones that depend on where inside a period something happens. One is a duty write that lands after a restart but before the next one. The other is a timer stop that falls part-way through a period. The stimulus aligns itself on an observed `period_hit` pulse and then acts a known number of clocks later. A scoreboard predicts the length and high time of every window between restart pulses, so any leak of the new duty into the current period shows up as a wrong high count. A lost or extra count during the hold shows up as a wrong period length.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

  typedef enum logic [1:0] {
    REG_PERIOD  = 2'd0,
    REG_DUTY_HI = 2'd1,
    REG_DUTY_LO = 2'd2,
    REG_CTRL    = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_PSEL_LSB = 1;
  localparam int CTRL_PSEL_W   = 2;
  localparam int CTRL_OE_BIT   = 3;

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_gen_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [1:0]              wr_addr,
  input  logic [TMR_W-1:0]        wr_data,
  output logic [TMR_W-1:0]        period,
  output logic [TMR_W+FRAC_W-1:0] duty_shadow,
  output logic                    tmr_en,
  output logic [CTRL_PSEL_W-1:0]  psel,
  output logic                    out_en
);

  logic [TMR_W-1:0]  period_q;
  logic [TMR_W-1:0]  duty_hi_q;
  logic [FRAC_W-1:0] duty_lo_q;
  logic              en_q;
  logic [CTRL_PSEL_W-1:0] psel_q;
  logic              oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q  <= '0;
      duty_hi_q <= '0;
      duty_lo_q <= '0;
      en_q      <= 1'b0;
      psel_q    <= '0;
      oe_q      <= 1'b0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_addr))
        REG_PERIOD:  period_q  <= wr_data;
        REG_DUTY_HI: duty_hi_q <= wr_data;
        REG_DUTY_LO: duty_lo_q <= wr_data[FRAC_W-1:0];
        REG_CTRL: begin
          en_q   <= wr_data[CTRL_EN_BIT];
          psel_q <= wr_data[CTRL_PSEL_LSB +: CTRL_PSEL_W];
          oe_q   <= wr_data[CTRL_OE_BIT];
        end
        default: ;
      endcase
    end
  end

  assign period      = period_q;
  assign duty_shadow = {duty_hi_q, duty_lo_q};
  assign tmr_en      = en_q;
  assign psel        = psel_q;
  assign out_en      = oe_q;

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int SEL_W    = 2,
  parameter int MAX_LOG4 = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  generate
    if (MAX_LOG4 == 0) begin : g_bypass
      assign tick = en;
    end else begin : g_div
      localparam int CNT_W = 2 * MAX_LOG4;
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] limit;
      int               sh;

      // Each select step multiplies the ratio by four, up to 4**MAX_LOG4.
      always_comb begin
        sh    = (int'(sel) > MAX_LOG4) ? MAX_LOG4 : int'(sel);
        limit = CNT_W'((32'd1 << (2 * sh)) - 32'd1);
      end

      // Using >= keeps the count bounded when the ratio is lowered mid-count.
      assign tick = en && (cnt_q >= limit);

      always_ff @(posedge clk) begin
        if (rst)
          cnt_q <= '0;
        else if (en)
          cnt_q <= tick ? '0 : cnt_q + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    tick,
  input  logic [TMR_W-1:0]        period,
  output logic [TMR_W-1:0]        timer_q,
  output logic [FRAC_W-1:0]       phase_q,
  output logic [TMR_W+FRAC_W-1:0] cnt_next,
  output logic                    step,
  output logic                    rollover,
  output logic                    hit_q
);

  logic             phase_last;
  logic [TMR_W-1:0]  timer_nx;
  logic [FRAC_W-1:0] phase_nx;

  assign step       = en && tick;
  assign phase_last = &phase_q;
  // Restart when the timer has reached or passed the period value.
  assign rollover   = step && phase_last && (timer_q >= period);

  always_comb begin
    timer_nx = timer_q;
    phase_nx = phase_q;
    if (step) begin
      phase_nx = phase_q + 1'b1;
      if (rollover)
        timer_nx = '0;
      else if (phase_last)
        timer_nx = timer_q + 1'b1;
    end
  end

  assign cnt_next = {timer_nx, phase_nx};

  always_ff @(posedge clk) begin
    if (rst) begin
      timer_q <= '0;
      phase_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      timer_q <= timer_nx;
      phase_q <= phase_nx;
      hit_q   <= rollover;
    end
  end

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              step,
  input  logic              rollover,
  input  logic [DUTY_W-1:0] cnt_next,
  input  logic [DUTY_W-1:0] duty_shadow,
  output logic [DUTY_W-1:0] act_duty_q,
  output logic              wave_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_duty_q <= '0;
      wave_q     <= 1'b0;
    end else begin
      if (rollover)
        act_duty_q <= duty_shadow;

      if (!en)
        wave_q <= 1'b0;
      else if (rollover)
        wave_q <= (duty_shadow != '0);
      else if (step && (cnt_next == act_duty_q))
        wave_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_timer_gen.sv
module pwm_timer_gen
  import pwm_gen_pkg::*;
#(
  parameter int TMR_W    = 8,
  parameter int FRAC_W   = 2,
  parameter int MAX_LOG4 = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [TMR_W-1:0] wr_data,
  output logic             pwm_out,
  output logic             period_hit
);

  localparam int DUTY_W = TMR_W + FRAC_W;

  logic [TMR_W-1:0]       period_w;
  logic [DUTY_W-1:0]      shadow_w;
  logic                   en_w;
  logic [CTRL_PSEL_W-1:0] psel_w;
  logic                   oe_w;
  logic                   tick_w;
  logic [TMR_W-1:0]       timer_w;
  logic [FRAC_W-1:0]      phase_w;
  logic [DUTY_W-1:0]      cnt_next_w;
  logic                   step_w;
  logic                   rollover_w;
  logic                   hit_w;
  logic [DUTY_W-1:0]      act_duty_w;
  logic                   wave_w;

  pwm_cfg_regs #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .period(period_w), .duty_shadow(shadow_w), .tmr_en(en_w), .psel(psel_w),
    .out_en(oe_w)
  );

  pwm_prescaler #(.SEL_W(CTRL_PSEL_W), .MAX_LOG4(MAX_LOG4)) u_pre (
    .clk(clk), .rst(rst), .en(en_w), .sel(psel_w), .tick(tick_w)
  );

  pwm_timebase #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_tb (
    .clk(clk), .rst(rst), .en(en_w), .tick(tick_w), .period(period_w),
    .timer_q(timer_w), .phase_q(phase_w), .cnt_next(cnt_next_w),
    .step(step_w), .rollover(rollover_w), .hit_q(hit_w)
  );

  pwm_compare #(.DUTY_W(DUTY_W)) u_cmp (
    .clk(clk), .rst(rst), .en(en_w), .step(step_w), .rollover(rollover_w),
    .cnt_next(cnt_next_w), .duty_shadow(shadow_w), .act_duty_q(act_duty_w),
    .wave_q(wave_w)
  );

  // Both operands are flops; the pin is released low when output enable is clear.
  assign pwm_out    = wave_w & oe_w;
  assign period_hit = hit_w;

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic [TMR_W-1:0]        timer,
  input logic [FRAC_W-1:0]       phase,
  input logic [TMR_W+FRAC_W-1:0] act_duty,
  input logic                    wave,
  input logic                    pwm_out,
  input logic                    period_hit
);

  p_hit_single_r2: assert property (@(posedge clk) disable iff (rst)
    period_hit |=> !period_hit);

  p_hit_at_zero_r2: assert property (@(posedge clk) disable iff (rst)
    period_hit |-> (timer == '0 && phase == '0));

  p_rise_on_hit_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(wave) |-> period_hit);

  p_zero_duty_low_r5: assert property (@(posedge clk) disable iff (rst)
    (act_duty == '0) |-> !wave);

  p_no_hit_off_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !period_hit);

  p_hold_count_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(timer) && $stable(phase)));

  p_out_low_off_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_out);

endmodule

bind pwm_timer_gen pwm_timer_chk #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .en(en_w), .timer(timer_w), .phase(phase_w),
  .act_duty(act_duty_w), .wave(wave_w), .pwm_out(pwm_out),
  .period_hit(period_hit)
);

// File: tb/tb_pwm_timer_gen.sv
module tb_pwm_timer_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out;
  logic       period_hit;

  typedef struct {
    int    len;
    int    high;
    string req;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  bit    mon_on = 1'b0;
  int    win_len = 0;
  int    win_hi  = 0;

  always #2 clk = ~clk;

  pwm_timer_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .period_hit(period_hit)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: measures each window between restart pulses and compares it.
  always @(negedge clk) begin
    item_t it;
    if (rst) begin
      mon_on = 1'b0;
    end else begin
      if (period_hit) begin
        if (mon_on && exp_q.size() > 0) begin
          it = exp_q.pop_front();
          check(win_len == it.len, it.req, "period length", win_len, it.len);
          check(win_hi == it.high, it.req, "high clocks", win_hi, it.high);
        end
        mon_on  = 1'b1;
        win_len = 0;
        win_hi  = 0;
      end
      if (mon_on) begin
        win_len++;
        if (pwm_out) win_hi++;
      end
    end
  end

  // Called at a negedge; returns at the next negedge after the write lands.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [7:0] ctrl(input bit en, input int psel, input bit oe);
    return {4'b0, oe, 2'(psel), en};
  endfunction

  function automatic int ratio(input int psel);
    return (psel == 0) ? 1 : (psel == 1) ? 4 : 16;   // R3
  endfunction

  task automatic push(input int len, input int high, input string req);
    item_t it;
    it.len = len; it.high = high; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // Reset, program (R1 map), enable, wait for the first restart pulse (R11).
  task automatic setup(input int p, input int d, input int psel, input bit oe);
    int hi;
    do_reset();
    wr(2'd0, 8'(p));
    wr(2'd1, 8'(d >> 2));
    wr(2'd2, 8'(d & 3));
    wr(2'd3, ctrl(1'b1, psel, oe));
    hi = 0;
    while (!period_hit) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    check(hi == 0, "R11", "high clocks before first restart", hi, 0);
  endtask

  task automatic scen(input int p, input int d, input int psel, input bit oe,
                      input int nper, input string req);
    int len, full, high;
    full = 4 * (p + 1);
    len  = full * ratio(psel);
    high = oe ? ((d < full) ? d : full) * ratio(psel) : 0;
    setup(p, d, psel, oe);
    for (int i = 0; i < nper; i++) push(len, high, req);
    drain();
  endtask

  initial begin
    int bad;
    @(negedge clk);
    do_reset();

    // R10: quiet after reset, also after period/duty writes without enable.
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      if (pwm_out || period_hit) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R10", "activity after reset", bad, 0);
    wr(2'd0, 8'd3);
    wr(2'd1, 8'd2);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      if (pwm_out || period_hit) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R10", "activity with timer stopped", bad, 0);

    scen(3, 5, 0, 1'b1, 2, "R1");     // R1 map, R2 length, R4 width
    scen(3, 11, 0, 1'b1, 2, "R4");    // fractional bits = 3
    scen(255, 700, 0, 1'b1, 1, "R2"); // longest period, 1024 clocks
    scen(3, 0, 0, 1'b1, 2, "R5");
    scen(3, 16, 0, 1'b1, 2, "R6");    // duty equal to full count
    scen(3, 1023, 0, 1'b1, 2, "R6");  // duty far beyond the period
    scen(2, 7, 1, 1'b1, 2, "R3");     // ratio 4
    scen(1, 3, 2, 1'b1, 2, "R3");     // ratio 16
    scen(1, 6, 3, 1'b1, 1, "R3");     // select 3 also ratio 16
    scen(3, 5, 0, 1'b0, 2, "R8");     // output enable clear

    // R7: duty rewritten just after a restart applies one period later.
    setup(7, 10, 0, 1'b1);
    push(32, 10, "R7");
    drain();
    wr(2'd1, 8'd5);
    wr(2'd2, 8'd0);
    push(32, 10, "R7");
    push(32, 20, "R7");
    drain();

    // R9: stop the timer 10 clocks into a period for 40 clocks.
    setup(3, 5, 0, 1'b1);
    push(16 + 40, 5, "R9");
    push(16, 5, "R9");
    repeat (10) @(negedge clk);
    wr(2'd3, ctrl(1'b0, 0, 1'b1));
    bad = 0;
    for (int i = 0; i < 39; i++) begin
      if (pwm_out || period_hit) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R9", "activity while stopped", bad, 0);
    wr(2'd3, ctrl(1'b1, 0, 1'b1));
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule